// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs the two-wire serial management bus that a MAC uses to reach the registers of an Ethernet PHY. Software programs a speed register with a clock divider and an output hold time. A single write of a 32-bit command word then launches one complete management frame. The block always sends the 32-bit preamble of ones, then shifts the command word out MSB first. MDC is derived from the system clock. MDIO changes only after a programmable number of system clocks has passed since each falling MDC edge.

For a read, the master releases MDIO for the turnaround and data bit times. It samples the PHY's data on the rising edges of MDC. When the frame ends, the returned 16 bits replace the low half of the command register. Completion is reported through a sticky event flag that software clears by writing a one to it. A data-register write while a frame is running is ignored. A divider value of zero keeps the bus parked.

Top module: `mdio_frame_master`

## Requirements
- R1: After reset MDC and MDIO output-enable are low, and the speed, command and event registers all read zero.
- R2: The speed register keeps the divider D in bits [6:1] and the hold value H in bits [10:8]. While a frame runs, MDC is high for D system clocks and low for D system clocks.
- R3: While D is zero, MDC stays low and a command write starts no frame. The write is dropped, so the command register still reads its old value and no event is raised.
- R4: A frame is 64 MDC periods. There are 32 ones, then command bits 31 down to 0: start [31:30]=01, opcode [29:28] (10 read, 01 write), PHY address [27:23], register address [22:18], turnaround [17:16]=10 and data [15:0]. The PHY samples each bit on the rising MDC edge.
- R5: Each change of MDIO output or output-enable inside a frame occurs exactly H+1 system clocks after the falling MDC edge that ends the previous bit. This holds when H+1 < D.
- R6: In a read frame (opcode 10), output-enable is low during bit times 46 to 63. The master samples MDIO on the rising MDC edges of bits 48 to 63. After completion, the command register reads its bits [31:16] unchanged and the PHY's 16 bits in [15:0].
- R7: Event bit 0 of the event register is set when a frame has finished. It stays 0 while the frame runs. Writing 1 to it clears it, and writing 0 to it leaves it set.
- R8: A command write while a frame is running is ignored. The frame on the wire and the command register are unchanged.
- R9: Between frames MDC is low and MDIO output-enable is low. Each frame produces exactly 64 rising MDC edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 speed, 1 command, 2 event |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO line as seen at the pad |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
A PHY model on the bench decodes every frame and answers reads. A scoreboard compares each frame with the expected one, bit by bit, and also checks output-enable. A design that dropped a preamble bit or shifted the field order would fail this comparison. So would one that kept driving during turnaround, which also shows up as bus contention. The bench counts system clocks from every falling MDC edge to each MDIO change, under several hold and divider settings. An off-by-one hold counter therefore shows up directly, and the bench also measures both MDC half-periods. It also writes the command register in the middle of a frame, with a zero divider, and writes 0 and then 1 to the event flag. A design that restarted, corrupted the frame or lost the sticky flag would fail these checks.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int TA_FIRST   = 46;
  localparam int DATA_FIRST = 48;

  localparam logic [1:0] REG_SPEED = 2'd0;
  localparam logic [1:0] REG_CMD   = 2'd1;
  localparam logic [1:0] REG_EVENT = 2'd2;
  localparam logic [1:0] OP_READ   = 2'b10;
  localparam int         EVT_BIT   = 0;

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_TAIL} seq_state_t;

  // bit i of the 64-bit frame: preamble ones, then command MSB first
  function automatic logic frame_bit(input logic [31:0] c, input logic [5:0] i);
    logic [5:0] k;
    k = 6'd63 - i;
    if (i < 6'(PRE_BITS)) return 1'b1;
    return c[k[4:0]];
  endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
`timescale 1ns/1ps
module mdio_clkdiv #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             mdc_q, mdc_d;
  logic             active, wrap;

  assign active = run && (div != '0);
  assign wrap   = (cnt_q == div - ONE);
  assign rise   = active && wrap && !mdc_q;
  assign fall   = active && wrap &&  mdc_q;
  assign mdc    = mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!active) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  AST_DIV_ZERO_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (div == '0) |=> !mdc_q); // R3
endmodule

// File: rtl/mdio_seq.sv
`timescale 1ns/1ps
module mdio_seq
  import mdio_pkg::*;
#(
  parameter int HOLD_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       cmd,
  input  logic [HOLD_W-1:0] hold,
  input  logic              rise,
  input  logic              fall,
  input  logic              mdio_i,
  output logic              run,
  output logic              busy,
  output logic              done,
  output logic [15:0]       rx_data,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam logic [5:0] LAST_IDX = 6'(FRAME_BITS - 1);

  seq_state_t        st_q, st_d;
  logic [5:0]        idx_q, idx_d, idx_nx;
  logic [HOLD_W-1:0] hcnt_q, hcnt_d;
  logic              pend_q, pend_d;
  logic              nxo_q, nxo_d, nxoe_q, nxoe_d;
  logic              o_q, o_d, oe_q, oe_d;
  logic [15:0]       rx_q, rx_d;
  logic              done_q, done_d;
  logic              is_rd, apply, nx_drive;

  assign is_rd    = (cmd[29:28] == OP_READ);
  assign apply    = pend_q && (hcnt_q == '0);
  assign idx_nx   = idx_q + 6'd1;
  assign nx_drive = !(is_rd && (idx_nx >= 6'(TA_FIRST)));

  always_comb begin
    st_d = st_q; idx_d = idx_q; hcnt_d = hcnt_q; pend_d = pend_q;
    nxo_d = nxo_q; nxoe_d = nxoe_q; o_d = o_q; oe_d = oe_q;
    rx_d = rx_q; done_d = 1'b0;
    if (pend_q) begin
      if (apply) begin
        o_d    = nxo_q;
        oe_d   = nxoe_q;
        pend_d = 1'b0;
      end else begin
        hcnt_d = hcnt_q - 1'b1;
      end
    end
    case (st_q)
      S_IDLE: if (start) begin
        st_d = S_SHIFT; idx_d = '0; pend_d = 1'b0;
        o_d = 1'b1; oe_d = 1'b1; rx_d = '0;
      end
      S_SHIFT: begin
        if (rise && (idx_q >= 6'(DATA_FIRST))) rx_d = {rx_q[14:0], mdio_i};
        if (fall) begin
          pend_d = 1'b1;
          hcnt_d = hold;
          if (idx_q == LAST_IDX) begin
            st_d = S_TAIL; nxo_d = 1'b0; nxoe_d = 1'b0;
          end else begin
            idx_d  = idx_nx;
            nxoe_d = nx_drive;
            nxo_d  = nx_drive && frame_bit(cmd, idx_nx);
          end
        end
      end
      S_TAIL: if (apply) begin
        st_d = S_IDLE; done_d = 1'b1;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; idx_q <= '0; hcnt_q <= '0; pend_q <= 1'b0;
      nxo_q <= 1'b0; nxoe_q <= 1'b0; o_q <= 1'b0; oe_q <= 1'b0;
      rx_q <= '0; done_q <= 1'b0;
    end else begin
      st_q <= st_d; idx_q <= idx_d; hcnt_q <= hcnt_d; pend_q <= pend_d;
      nxo_q <= nxo_d; nxoe_q <= nxoe_d; o_q <= o_d; oe_q <= oe_d;
      rx_q <= rx_d; done_q <= done_d;
    end
  end

  assign run     = (st_q == S_SHIFT);
  assign busy    = (st_q != S_IDLE);
  assign done    = done_q;
  assign rx_data = rx_q;
  assign mdio_o  = o_q;
  assign mdio_oe = oe_q;

  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_SHIFT && is_rd && idx_q >= 6'(TA_FIRST) && !pend_q) |-> !oe_q); // R6
endmodule

// File: rtl/mdio_frame_master.sv
`timescale 1ns/1ps
module mdio_frame_master
  import mdio_pkg::*;
#(
  parameter int DIV_W  = 6,
  parameter int HOLD_W = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);
  localparam int HOLD_LSB = 8;
  localparam int HOLD_MSB = HOLD_LSB + HOLD_W - 1;

  logic [DIV_W-1:0]  div_q, div_d;
  logic [HOLD_W-1:0] hold_q, hold_d;
  logic [31:0]       cmd_q, cmd_d;
  logic              evt_q, evt_d;
  logic              launch, busy, run, done, rise, fall;
  logic [15:0]       rx_data;

  assign launch = bus_we && (bus_addr == REG_CMD) && !busy && (div_q != '0);

  always_comb begin
    div_d = div_q; hold_d = hold_q; cmd_d = cmd_q; evt_d = evt_q;
    if (bus_we && bus_addr == REG_SPEED) begin
      div_d  = bus_wdata[DIV_W:1];
      hold_d = bus_wdata[HOLD_MSB:HOLD_LSB];
    end
    if (launch) cmd_d = bus_wdata;
    else if (done && cmd_q[29:28] == OP_READ) cmd_d[15:0] = rx_data;
    if (bus_we && bus_addr == REG_EVENT && bus_wdata[EVT_BIT]) evt_d = 1'b0;
    if (done) evt_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0; hold_q <= '0; cmd_q <= '0; evt_q <= 1'b0;
    end else begin
      div_q <= div_d; hold_q <= hold_d; cmd_q <= cmd_d; evt_q <= evt_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_SPEED: begin
        bus_rdata[DIV_W:1]           = div_q;
        bus_rdata[HOLD_MSB:HOLD_LSB] = hold_q;
      end
      REG_CMD:   bus_rdata = cmd_q;
      REG_EVENT: bus_rdata[EVT_BIT] = evt_q;
      default:   bus_rdata = '0;
    endcase
  end

  mdio_clkdiv #(.DIV_W(DIV_W)) i_clkdiv (
    .clk(clk), .rst_n(rst_n), .run(run), .div(div_q),
    .mdc(mdc), .rise(rise), .fall(fall)
  );

  mdio_seq #(.HOLD_W(HOLD_W)) i_seq (
    .clk(clk), .rst_n(rst_n), .start(launch), .cmd(cmd_q), .hold(hold_q),
    .rise(rise), .fall(fall), .mdio_i(mdio_i), .run(run), .busy(busy),
    .done(done), .rx_data(rx_data), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  AST_IDLE_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe)); // R9
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc) && (int'(hold_q) + 1 < int'(div_q))) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R5
  AST_EVENT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_q) |-> $past(done)); // R7
  AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cmd_q)); // R8
endmodule

// File: tb/test_mdio_frame_master.sv
`timescale 1ns/1ps
module test_mdio_frame_master;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;
  logic        phy_oe = 1'b0, phy_d = 1'b0;

  int n_chk = 0, n_err = 0;
  int cfg_div = 0, cfg_hold = 0;
  int frames_seen = 0, rises_total = 0;
  logic [31:0] exp_q[$];

  always #2.5 clk = ~clk;
  assign mdio_i = phy_oe ? phy_d : 1'b1;

  mdio_frame_master i_mdio_frame_master (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] phy_val(input logic [4:0] pa, input logic [4:0] ra);
    return {pa, ra, 6'h2B} ^ 16'h5A3C;
  endfunction

  function automatic logic [31:0] mk_cmd(input bit rd, input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] d);
    return {2'b01, (rd ? 2'b10 : 2'b01), pa, ra, 2'b10, d};
  endfunction

  // ---------------- PHY responder and scoreboard monitor ----------------
  logic bo[64];
  logic boe[64];
  int   pc = 0;

  always @(posedge mdc) begin
    bo[pc]  = mdio_o;
    boe[pc] = mdio_oe;
    pc++;
    rises_total++;
    if (pc == 64) begin
      logic [31:0] e;
      bit rd, ok;
      int bad;
      ok = 1'b1; bad = -1;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 unexpected frame", 32'd0, 32'd1);
      end else begin
        e  = exp_q.pop_front();
        rd = (e[29:28] == 2'b10);
        for (int i = 0; i < 64; i++) begin
          logic eb;
          eb = (i < 32) ? 1'b1 : e[63 - i];
          if (rd && i >= 46) begin
            if (boe[i] !== 1'b0) begin ok = 1'b0; if (bad < 0) bad = i; end
          end else if (boe[i] !== 1'b1 || bo[i] !== eb) begin
            ok = 1'b0; if (bad < 0) bad = i;
          end
        end
        chk(ok, rd ? "R4/R6 frame bits" : "R4 frame bits", bad, 32'hFFFFFFFF);
      end
      frames_seen++;
      pc = 0;
    end
  end

  always @(negedge mdc) begin
    #1;
    if (pc >= 46 && bo[34] === 1'b1 && bo[35] === 1'b0) begin
      logic [15:0] v;
      v = phy_val({bo[36], bo[37], bo[38], bo[39], bo[40]}, {bo[41], bo[42], bo[43], bo[44], bo[45]});
      if (pc == 47) begin phy_oe = 1'b1; phy_d = 1'b0; end
      else if (pc >= 48 && pc <= 63) begin phy_oe = 1'b1; phy_d = v[63 - pc]; end
      else phy_oe = 1'b0;
    end else begin
      phy_oe = 1'b0;
    end
  end

  // ---------------- timing monitor: hold time and MDC half periods ----------------
  logic pm = 1'b0, po = 1'b0, poe = 1'b0;
  bit   armed = 1'b0, lo_ok = 1'b0;
  int   since = 0, hi_cnt = 0, lo_cnt = 0;

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (mdio_oe && phy_oe) chk(1'b0, "R6 bus contention", 32'd1, 32'd0);
      if (pm && !mdc) begin
        chk(hi_cnt == cfg_div, "R2 MDC high time", hi_cnt, cfg_div);
        hi_cnt = 0; armed = 1'b1; since = 0; lo_cnt = 0; lo_ok = 1'b1;
      end else begin
        if (armed) since++;
        if (since > 2 * cfg_div) armed = 1'b0;
      end
      if (!pm && mdc) begin
        if (lo_ok) chk(lo_cnt == cfg_div, "R2 MDC low time", lo_cnt, cfg_div);
        lo_ok = 1'b0;
      end
      if (mdc) hi_cnt++; else lo_cnt++;
      if (lo_cnt > 2 * cfg_div) lo_ok = 1'b0;
      if (armed && (mdio_o !== po || mdio_oe !== poe)) begin
        chk(since == cfg_hold + 1, "R5 hold time", since, cfg_hold + 1);
        armed = 1'b0;
      end
      pm = mdc; po = mdio_o; poe = mdio_oe;
    end
  end

  // ---------------- bus driver ----------------
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_speed(input int dv, input int h);
    logic [31:0] r;
    cfg_div = dv; cfg_hold = h;
    wr(2'd0, (32'(dv) << 1) | (32'(h) << 8));
    rd(2'd0, r);
    chk(r == ((32'(dv) << 1) | (32'(h) << 8)), "R2 speed readback", r, (32'(dv) << 1) | (32'(h) << 8));
  endtask

  task automatic wait_evt();
    logic [31:0] r;
    for (int k = 0; k < 4000; k++) begin
      rd(2'd2, r);
      if (r[0]) return;
    end
    chk(1'b0, "R7 event never set", 32'd0, 32'd1);
  endtask

  task automatic run_frame(input logic [31:0] c);
    logic [31:0] r, e;
    exp_q.push_back(c);
    wr(2'd1, c);
    repeat (40) @(negedge clk);
    rd(2'd2, r);
    chk(r == 32'd0, "R7 event low while busy", r, 32'd0);
    wait_evt();
    e = (c[29:28] == 2'b10) ? {c[31:16], phy_val(c[27:23], c[22:18])} : c;
    rd(2'd1, r);
    chk(r == e, (c[29:28] == 2'b10) ? "R6 read data" : "R4 cmd readback", r, e);
    repeat (3) @(negedge clk);
    chk(!mdc && !mdio_oe, "R9 idle after frame", {mdc, mdio_oe}, 32'd0);
    wr(2'd2, 32'd1);
  endtask

  // ---------------- main sequence ----------------
  initial begin
    logic [31:0] r;
    int rises0, fr0;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(!mdc && !mdio_oe, "R1 outputs after reset", {mdc, mdio_oe}, 32'd0);
    rd(2'd0, r); chk(r == 0, "R1 speed reg", r, 0);
    rd(2'd1, r); chk(r == 0, "R1 cmd reg", r, 0);
    rd(2'd2, r); chk(r == 0, "R1 event reg", r, 0);

    // R3 divider zero: no frame
    wr(2'd1, mk_cmd(1'b1, 5'd3, 5'd1, 16'h0));
    repeat (300) @(negedge clk);
    chk(rises_total == 0, "R3 MDC parked", rises_total, 0);
    rd(2'd1, r); chk(r == 0, "R3 write dropped", r, 0);
    rd(2'd2, r); chk(r == 0, "R3 no event", r, 0);

    set_speed(4, 1);
    run_frame(mk_cmd(1'b0, 5'd5, 5'd9, 16'hC3A5));
    chk(rises_total == 64, "R9 64 MDC edges", rises_total, 64);
    set_speed(3, 0);
    run_frame(mk_cmd(1'b1, 5'd17, 5'd2, 16'h0));
    set_speed(6, 3);
    run_frame(mk_cmd(1'b1, 5'd31, 5'd30, 16'hFFFF));
    set_speed(5, 2);
    run_frame(mk_cmd(1'b0, 5'd0, 5'd31, 16'h8001));

    // R8 write during a frame is ignored
    set_speed(4, 2);
    exp_q.push_back(mk_cmd(1'b0, 5'd10, 5'd20, 16'h1234));
    fr0 = frames_seen;
    wr(2'd1, mk_cmd(1'b0, 5'd10, 5'd20, 16'h1234));
    repeat (60) @(negedge clk);
    wr(2'd1, mk_cmd(1'b1, 5'd1, 5'd1, 16'hBEEF));
    wait_evt();
    rd(2'd1, r);
    chk(r == mk_cmd(1'b0, 5'd10, 5'd20, 16'h1234), "R8 cmd unchanged", r, mk_cmd(1'b0, 5'd10, 5'd20, 16'h1234));
    rises0 = rises_total;
    repeat (700) @(negedge clk);
    chk(rises_total == rises0 && frames_seen == fr0 + 1, "R8 no second frame", frames_seen, fr0 + 1);

    // R7 write-one-to-clear
    wr(2'd2, 32'd0);
    rd(2'd2, r); chk(r == 1, "R7 write 0 keeps event", r, 1);
    wr(2'd2, 32'd1);
    rd(2'd2, r); chk(r == 0, "R7 write 1 clears event", r, 0);

    chk(exp_q.size() == 0, "R4 all frames seen", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #750000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule